// File: doc/BRIEF.md
# Miss Fill Handler for a Direct-Mapped Write-Back Data Cache

This block completes an outstanding miss in a small direct-mapped, write-back data cache. It holds the tag and coherence state of every line. A fill reply brings a line address, a reply kind (shared, exclusive or upgrade), a flag that says whether any request merged into the miss was a store, and a flag that says a flush is pending on the miss entry. The handler updates the indexed line in the cycle the reply is accepted. If the line is already resident, only its state moves to private-dirty. Otherwise the occupant is evicted and the new tag is written with a state chosen from the reply kind and the store flag.

When the evicted line was private-dirty, a write-back of its line address is offered to the lower-level request queue in a phase of its own. The handler holds the offer while that queue reports full, and it does not repeat the line update during the stall. It then raises a one-cycle completion pulse, which releases every request merged into the entry. A pending flush invalidates the freshly filled line directly after that pulse. On the cycle after acceptance, one of three strobes reports the class of the evicted line, for statistics counters outside the block. A combinational lookup port reports the tag and state for any line address.

Top module: `mfh_fill_handler`

## Requirements
- R1: After reset every line is invalid, so the lookup reports a miss for any address. `rep_ready` is 1 and `wb_valid`, `done` and the three victim strobes are 0.
- R2: A fill whose tag matches a valid line at its index sets that line to private-dirty (2'b11) and leaves its tag unchanged. It raises no victim strobe and no write-back, for every reply kind.
- R3: A fill that misses writes its tag, the line address shifted right by `INDEX_W`, into the indexed line. After that, the lookup hits for the new line address and misses for the previous occupant's.
- R4: A newly installed line gets state private-dirty (2'b11) if `rep_has_writes` is 1. Otherwise it gets shared-clean (2'b01) for reply kind 2'b00 (shared) and private-clean (2'b10) for kinds 2'b01 (exclusive) and 2'b10 (upgrade). Invalid is 2'b00.
- R5: On the cycle after a missing fill is accepted, exactly one of `vic_sc`, `vic_pc`, `vic_pd` is high for one cycle if the victim held state 01, 10 or 11 respectively. None is high if the victim was invalid.
- R6: When a missing fill evicts a private-dirty line, `wb_valid` rises on the cycle after acceptance with `wb_line` equal to the victim's `{tag, index}`. Both hold steady while `wb_full` is 1. A fill whose victim is not dirty raises no `wb_valid` and is not delayed by `wb_full`.
- R7: While a write-back is held off by `wb_full`, `done` stays 0 and the filled line keeps the state written at acceptance.
- R8: `done` is high for exactly one cycle per fill. This is the cycle after acceptance when there is no write-back, or the cycle after the write-back is taken (`wb_valid` and not `wb_full`).
- R9: With `rep_flush` set, the filled line is invalid from the cycle after the `done` pulse. Without it, the line keeps the state of R2 or R4.
- R10: `rep_ready` is 0 from acceptance until the cycle after `done`. A reply presented during that time is ignored and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_valid | input | 1 | Fill reply present |
| rep_ready | output | 1 | Handler idle; reply taken when both are high |
| rep_line | input | LINE_W | Line address of the fill (tag above index) |
| rep_kind | input | 2 | 00 shared, 01 exclusive, 10 upgrade |
| rep_has_writes | input | 1 | A merged request was a store |
| rep_flush | input | 1 | Flush pending on the miss entry |
| wb_valid | output | 1 | Write-back offered to lower queue |
| wb_full | input | 1 | Lower queue full; hold the write-back |
| wb_line | output | LINE_W | Line address of the dirty victim |
| vic_sc | output | 1 | Victim was shared-clean (one-cycle strobe) |
| vic_pc | output | 1 | Victim was private-clean (one-cycle strobe) |
| vic_pd | output | 1 | Victim was private-dirty (one-cycle strobe) |
| done | output | 1 | One-cycle completion of the miss entry |
| lk_line | input | LINE_W | Lookup line address |
| lk_hit | output | 1 | Lookup line valid with matching tag |
| lk_state | output | 2 | State of the looked-up line, 00 on miss |

## Verification
The bench sweeps hundreds of fills over every index with a few colliding tags, all reply kinds, both store flags, flushes, and write-back stalls of zero to three cycles. It keeps its own tag and state model. The sweep goes after upgrades of resident lines: a design that rewrote the tag or evicted there would raise a spurious strobe or write-back. It goes after dirty evictions under backpressure: a design that redid the update during a stall would lose the victim address or pulse `done` early. It also covers flush-after-fill, where a design that invalidated before completion or kept the line would show up on the lookup. Replies held high while the handler is busy check that a design accepting them would corrupt a line with the junk tag.

// File: rtl/mfh_pkg.sv
package mfh_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SC  = 2'b01,
        LS_PC  = 2'b10,
        LS_PD  = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        RK_SHARED  = 2'b00,
        RK_EXCL    = 2'b01,
        RK_UPGRADE = 2'b10
    } reply_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_WBACK = 2'b01,
        PH_DONE  = 2'b10
    } phase_e;
endpackage

// File: rtl/mfh_state_pick.sv
module mfh_state_pick
    import mfh_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       has_writes,
    output logic [1:0] state
);
    always_comb begin
        if (has_writes) begin
            state = LS_PD;
        end else if (kind == RK_SHARED) begin
            state = LS_SC;
        end else begin
            state = LS_PC;
        end
    end
endmodule

// File: rtl/mfh_line_store.sv
module mfh_line_store
    import mfh_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic               wr_tag_en,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [1:0]         wr_state,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [1:0]         rd_state,
    input  logic [INDEX_W-1:0] lk_idx,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [1:0]         lk_state
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0][TAG_W-1:0] tag_all;
    logic [LINES-1:0][1:0]       st_all;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_d, tag_q;
        logic [1:0]       st_d, st_q;

        always_comb begin
            tag_d = tag_q;
            st_d  = st_q;
            if (wr_en && (wr_idx == INDEX_W'(g))) begin
                st_d = wr_state;
                if (wr_tag_en) begin
                    tag_d = wr_tag;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                st_q  <= LS_INV;
            end else begin
                tag_q <= tag_d;
                st_q  <= st_d;
            end
        end

        assign tag_all[g] = tag_q;
        assign st_all[g]  = st_q;
    end

    assign rd_tag   = tag_all[rd_idx];
    assign rd_state = st_all[rd_idx];
    assign lk_tag   = tag_all[lk_idx];
    assign lk_state = st_all[lk_idx];
endmodule

// File: rtl/mfh_fill_handler.sv
module mfh_fill_handler
    import mfh_pkg::*;
#(
    parameter int LINE_W    = 12,
    parameter int INDEX_W   = 3,
    parameter bit WB_ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_valid,
    output logic              rep_ready,
    input  logic [LINE_W-1:0] rep_line,
    input  logic [1:0]        rep_kind,
    input  logic              rep_has_writes,
    input  logic              rep_flush,
    output logic              wb_valid,
    input  logic              wb_full,
    output logic [LINE_W-1:0] wb_line,
    output logic              vic_sc,
    output logic              vic_pc,
    output logic              vic_pd,
    output logic              done,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic [1:0]        lk_state
);
    localparam int TAG_W = LINE_W - INDEX_W;

    typedef struct packed {
        phase_e             phase;
        logic [INDEX_W-1:0] idx;
        logic               flush;
        logic [LINE_W-1:0]  vline;
        logic [2:0]         vic;
    } regs_t;

    regs_t r_d, r_q;

    logic [INDEX_W-1:0] rep_idx;
    logic [TAG_W-1:0]   rep_tag;
    logic [TAG_W-1:0]   old_tag;
    logic [1:0]         old_state;
    logic [1:0]         pick_state;
    logic               resident;

    logic               ws_en;
    logic [INDEX_W-1:0] ws_idx;
    logic               ws_tag_en;
    logic [TAG_W-1:0]   ws_tag;
    logic [1:0]         ws_state;

    logic [TAG_W-1:0]   lk_tag_raw;
    logic [1:0]         lk_state_raw;

    assign rep_idx  = rep_line[INDEX_W-1:0];
    assign rep_tag  = rep_line[LINE_W-1:INDEX_W];
    assign resident = (old_state != LS_INV) && (old_tag == rep_tag);

    mfh_state_pick u_pick (
        .kind       (rep_kind),
        .has_writes (rep_has_writes),
        .state      (pick_state)
    );

    mfh_line_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ws_en),
        .wr_idx    (ws_idx),
        .wr_tag_en (ws_tag_en),
        .wr_tag    (ws_tag),
        .wr_state  (ws_state),
        .rd_idx    (rep_idx),
        .rd_tag    (old_tag),
        .rd_state  (old_state),
        .lk_idx    (lk_line[INDEX_W-1:0]),
        .lk_tag    (lk_tag_raw),
        .lk_state  (lk_state_raw)
    );

    always_comb begin
        r_d       = r_q;
        r_d.vic   = 3'b000;
        ws_en     = 1'b0;
        ws_idx    = rep_idx;
        ws_tag_en = 1'b0;
        ws_tag    = rep_tag;
        ws_state  = pick_state;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (rep_valid) begin
                    ws_en     = 1'b1;
                    r_d.idx   = rep_idx;
                    r_d.flush = rep_flush;
                    r_d.vline = {old_tag, rep_idx};
                    if (resident) begin
                        ws_state  = LS_PD;
                        r_d.phase = PH_DONE;
                    end else begin
                        ws_tag_en = 1'b1;
                        r_d.vic   = {old_state == LS_PD, old_state == LS_PC,
                                     old_state == LS_SC};
                        r_d.phase = (WB_ENABLE && (old_state == LS_PD))
                                    ? PH_WBACK : PH_DONE;
                    end
                end
            end
            PH_WBACK: begin
                if (!wb_full) begin
                    r_d.phase = PH_DONE;
                end
            end
            PH_DONE: begin
                if (r_q.flush) begin
                    ws_en     = 1'b1;
                    ws_idx    = r_q.idx;
                    ws_tag_en = 1'b1;
                    ws_tag    = '0;
                    ws_state  = LS_INV;
                end
                r_d.phase = PH_IDLE;
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, idx: '0, flush: 1'b0, vline: '0, vic: 3'b000};
        end else begin
            r_q <= r_d;
        end
    end

    assign rep_ready = (r_q.phase == PH_IDLE);
    assign wb_valid  = (r_q.phase == PH_WBACK);
    assign wb_line   = r_q.vline;
    assign done      = (r_q.phase == PH_DONE);
    assign vic_sc    = r_q.vic[0];
    assign vic_pc    = r_q.vic[1];
    assign vic_pd    = r_q.vic[2];

    assign lk_hit   = (lk_state_raw != LS_INV) && (lk_tag_raw == lk_line[LINE_W-1:INDEX_W]);
    assign lk_state = lk_hit ? lk_state_raw : LS_INV;
endmodule

// File: rtl/mfh_fill_handler_chk.sv
module mfh_fill_handler_chk #(
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rep_valid,
    input logic              rep_ready,
    input logic              wb_valid,
    input logic              wb_full,
    input logic [LINE_W-1:0] wb_line,
    input logic              vic_sc,
    input logic              vic_pc,
    input logic              vic_pd,
    input logic              done
);
    // R5: at most one victim class per fill
    a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vic_sc, vic_pc, vic_pd}));

    // R5: a strobe only follows an accepted reply
    a_r5_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_sc || vic_pc || vic_pd) |-> $past(rep_valid && rep_ready));

    // R6: a stalled write-back holds its offer and address
    a_r6_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_full) |=> (wb_valid && $stable(wb_line)));

    // R7: no completion while the write-back is outstanding
    a_r7_no_done_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !done);

    // R8: completion lasts one cycle
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy phases refuse new replies
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid || done) |-> !rep_ready);
endmodule

bind mfh_fill_handler mfh_fill_handler_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rep_valid (rep_valid),
    .rep_ready (rep_ready),
    .wb_valid  (wb_valid),
    .wb_full   (wb_full),
    .wb_line   (wb_line),
    .vic_sc    (vic_sc),
    .vic_pc    (vic_pc),
    .vic_pd    (vic_pd),
    .done      (done)
);

// File: tb/mfh_fill_handler_tb.sv
module mfh_fill_handler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 12;
    localparam int INDEX_W    = 3;
    localparam int TAG_W      = LINE_W - INDEX_W;
    localparam int LINES      = 1 << INDEX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rep_valid = 1'b0;
    logic              rep_ready;
    logic [LINE_W-1:0] rep_line = '0;
    logic [1:0]        rep_kind = 2'b00;
    logic              rep_has_writes = 1'b0;
    logic              rep_flush = 1'b0;
    logic              wb_valid;
    logic              wb_full = 1'b0;
    logic [LINE_W-1:0] wb_line;
    logic              vic_sc, vic_pc, vic_pd;
    logic              done;
    logic [LINE_W-1:0] lk_line = '0;
    logic              lk_hit;
    logic [1:0]        lk_state;

    int checks = 0;
    int errors = 0;

    logic [TAG_W-1:0] m_tag [LINES];
    logic [1:0]       m_st  [LINES];

    always #(CLK_PERIOD/2) clk = ~clk;

    mfh_fill_handler #(.LINE_W(LINE_W), .INDEX_W(INDEX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_ready(rep_ready),
        .rep_line(rep_line), .rep_kind(rep_kind), .rep_has_writes(rep_has_writes),
        .rep_flush(rep_flush), .wb_valid(wb_valid), .wb_full(wb_full),
        .wb_line(wb_line), .vic_sc(vic_sc), .vic_pc(vic_pc), .vic_pd(vic_pd),
        .done(done), .lk_line(lk_line), .lk_hit(lk_hit), .lk_state(lk_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [TAG_W-1:0] t,
                        input logic [INDEX_W-1:0] i, input logic eh, input logic [1:0] es);
        lk_line = {t, i};
        #1;
        chk({req, " lookup hit"}, 32'(lk_hit), 32'(eh));
        chk({req, " lookup state"}, 32'(lk_state), 32'(es));
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < LINES; i++) begin
            look(req, m_tag[i], INDEX_W'(i), m_st[i] != 2'b00, m_st[i]);
            look({req, " junk tag"}, '1, INDEX_W'(i), 1'b0, 2'b00);
        end
    endtask

    task automatic do_fill(input logic [TAG_W-1:0] t, input logic [INDEX_W-1:0] i,
                           input logic [1:0] kind, input logic hw, input logic fl,
                           input int stall);
        logic             res;
        logic [1:0]       vic;
        logic [1:0]       nst;
        logic             need_wb;
        logic [TAG_W-1:0] otag;
        @(negedge clk);
        res     = (m_st[i] != 2'b00) && (m_tag[i] == t);
        vic     = m_st[i];
        otag    = m_tag[i];
        need_wb = !res && (vic == 2'b11);
        nst     = res ? 2'b11 : (hw ? 2'b11 : (kind == 2'b00 ? 2'b01 : 2'b10));
        chk("R10 ready when idle", 32'(rep_ready), 32'd1);
        rep_valid = 1'b1; rep_line = {t, i}; rep_kind = kind;
        rep_has_writes = hw; rep_flush = fl; wb_full = (stall != 0);
        @(negedge clk);
        // R10: keep a junk reply on the port while busy
        rep_line = {{TAG_W{1'b1}}, i}; rep_kind = 2'b00; rep_has_writes = 1'b0;
        rep_flush = 1'b0;
        if (res) begin
            chk("R2 no strobe on upgrade", 32'({vic_sc, vic_pc, vic_pd}), 32'd0);
            chk("R2 no writeback on upgrade", 32'(wb_valid), 32'd0);
        end else begin
            chk("R5 strobe sc", 32'(vic_sc), 32'(vic == 2'b01));
            chk("R5 strobe pc", 32'(vic_pc), 32'(vic == 2'b10));
            chk("R5 strobe pd", 32'(vic_pd), 32'(vic == 2'b11));
        end
        m_tag[i] = t;
        m_st[i]  = nst;
        if (need_wb) begin
            chk("R6 writeback offered", 32'(wb_valid), 32'd1);
            chk("R6 writeback line", 32'(wb_line), 32'({otag, i}));
            chk("R7 no done before writeback", 32'(done), 32'd0);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk("R6 writeback held", 32'(wb_valid), 32'd1);
                chk("R6 writeback line stable", 32'(wb_line), 32'({otag, i}));
                chk("R7 no done while stalled", 32'(done), 32'd0);
                chk("R10 not ready while stalled", 32'(rep_ready), 32'd0);
                look("R7 state kept during stall", t, i, 1'b1, nst);
            end
            wb_full = 1'b0;
            @(negedge clk);
        end else begin
            chk("R6 no writeback for clean victim", 32'(wb_valid), 32'd0);
        end
        chk("R8 done pulse", 32'(done), 32'd1);
        chk("R10 not ready during done", 32'(rep_ready), 32'd0);
        look(res ? "R2 upgrade state" : "R4 installed state", t, i, 1'b1, nst);
        if (!res && vic != 2'b00) begin
            look("R3 old occupant gone", otag, i, 1'b0, 2'b00);
        end
        @(negedge clk);
        rep_valid = 1'b0; wb_full = 1'b0;
        chk("R8 done lasts one cycle", 32'(done), 32'd0);
        chk("R10 ready after done", 32'(rep_ready), 32'd1);
        if (fl) begin
            m_st[i]  = 2'b00;
            m_tag[i] = '0;
            look("R9 flushed line invalid", t, i, 1'b0, 2'b00);
        end else begin
            look("R9 unflushed line kept", t, i, 1'b1, nst);
        end
        check_all("R3 R10 array");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = '0;
            m_st[i]  = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(rep_ready), 32'd1);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 strobes", 32'({vic_sc, vic_pc, vic_pd}), 32'd0);
        for (int i = 0; i < LINES; i++) begin
            look("R1 empty", '0, INDEX_W'(i), 1'b0, 2'b00);
        end
        // Directed: each R4 state then dirty eviction with stall
        do_fill(9'd1, 3'd0, 2'b00, 1'b0, 1'b0, 0);
        do_fill(9'd2, 3'd0, 2'b01, 1'b0, 1'b0, 0);
        do_fill(9'd3, 3'd0, 2'b10, 1'b1, 1'b0, 2);
        do_fill(9'd4, 3'd0, 2'b10, 1'b0, 1'b0, 3);
        do_fill(9'd4, 3'd0, 2'b10, 1'b0, 1'b1, 1);
        // Sweep
        for (int k = 0; k < 320; k++) begin
            do_fill(TAG_W'(1 + ((k / 8 + k / 5) % 3)), INDEX_W'(k % LINES),
                    2'(k % 3), 1'((k / 3) % 2), (k % 13) == 5, (k / 2) % 4);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule